// File: doc/BRIEF.md
# Dual-Context Interrupt Enable Register File

This block holds the interrupt-control state for a core that time-shares two hardware execution contexts. A byte-wide register port reaches a mode register, the interrupt-enable bits and the interrupt flags. Bit 4 of the mode register names the active context. Each context has its own 12-bit enable register and one mask bit. Both contexts reach their enable registers through the same two byte addresses. Reads always show the active context's enables. A write goes to the context whose deferred data write is still outstanding. If nothing is outstanding, the write goes to the active context.

The core drives three more inputs. It pulses a strobe at each instruction boundary, and at that point the block may hand control to the other context. It also pulses signals that queue a deferred write and that retire it. A separate set/clear port updates the 12-bit flag register. Software can only read the flags. The context-select bit changes only through the swap rule at a boundary and never through a register write.

Top module: `ctxirq_regs`

## Requirements
- R1: Reset loads the mode register with 0x0C, clears both enable registers and the flags, sets both mask bits to 1 (so the low enable byte reads 0x30) and loads the pending tag with 0xFF. Context 0 is then active.
- R2: Register addresses are 0 for mode, 1 for the low enable byte, 2 for the high enable byte, 3 for flags 7:0 and 4 for flags 11:8. A mode write updates every bit except bit 4, which keeps its old value. Reading the mode register returns it unchanged.
- R3: At a boundary strobe, bit 4 toggles unless mode[1:0] is 01 while bit 4 is 1, or 10 while bit 4 is 0. The `active_ctx` output follows bit 4.
- R4: The low enable byte reads back as the active context's enable bits 3:0 in bits 3:0, context 0's mask in bit 4 and context 1's mask in bit 5. Bits 7:6 read as zero.
- R5: A low-byte write replaces enable bits 3:0 of the target context. Data bits 4 and 5 always load the masks of context 0 and context 1, whichever context is active.
- R6: The high enable byte reads the active context's enable bits 11:4. A write to it replaces those bits in the target context.
- R7: Enable writes leave the other context's enable register unchanged.
- R8: `defer_queue` loads the pending tag with the index of the context active in that cycle. `defer_commit` alone returns the tag to 0xFF. If both arrive in the same cycle, the queue wins.
- R9: While the tag is not 0xFF, enable writes go to the context it names, even after a swap.
- R10: If a register write and a boundary strobe fall in the same cycle, the write uses the context selection from before the swap.
- R11: Each flag bit is set by `flag_set` and cleared by `flag_clr`, and set wins when both are raised. The bits above flag 11 in the high flag byte read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data |
| boundary | input | 1 | Instruction-boundary strobe (may swap contexts) |
| defer_queue | input | 1 | Deferred data write queued this cycle |
| defer_commit | input | 1 | Deferred data write retired this cycle |
| flag_set | input | 12 | Per-bit flag set |
| flag_clr | input | 12 | Per-bit flag clear |
| active_ctx | output | 1 | Currently active context |
| pending_tag | output | 8 | Owner of pending deferred write, 0xFF if none |

## Verification
The properties assume that reset is asserted from time zero until the first clock edges. They also assume that every strobe is a synchronous level sampled at the rising edge, so they hold for any mix of writes, boundaries and deferred-write events. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It uses only the five defined addresses. It commits a deferred write only after queuing one, except for the deliberate case where a queue and a commit arrive in the same cycle. Under those conditions the tag only ever holds 0, 1 or 0xFF, which is what the tag-range property expects.

// File: rtl/ctxirq_pkg.sv
package ctxirq_pkg;
    localparam int DW       = 8;
    localparam int ADDR_W   = 3;
    localparam int NCTX     = 2;
    localparam int EN_W     = 12;
    localparam int FLAG_W   = 12;
    localparam int EN_LO_W  = 4;
    localparam int EN_HI_W  = EN_W - EN_LO_W;
    localparam int FLAG_HI_W = FLAG_W - DW;
    localparam int CTX_BIT  = 4;
    localparam int MASK0_BIT = 4;
    localparam logic [DW-1:0] TAG_NONE = 8'hFF;
    localparam logic [DW-1:0] MODE_RST = 8'h0C;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE    = 3'd0,
        A_EN_LO   = 3'd1,
        A_EN_HI   = 3'd2,
        A_FLAG_LO = 3'd3,
        A_FLAG_HI = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [EN_W-1:0] en;
        logic            mask;
    } ctx_state_t;

    // A boundary hands over control unless the mode's low bits pin the current context.
    function automatic logic swap_needed(input logic [DW-1:0] mode);
        return mode[CTX_BIT] ? (mode[1:0] != 2'b01) : (mode[1:0] != 2'b10);
    endfunction
endpackage

// File: rtl/ctxirq_mode.sv
module ctxirq_mode
    import ctxirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          boundary,
    output logic [DW-1:0] mode_q
);
    logic [DW-1:0] mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wdata;
            mode_d[CTX_BIT] = mode_q[CTX_BIT];
        end
        if (boundary && swap_needed(mode_q))
            mode_d[CTX_BIT] = ~mode_q[CTX_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RST;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/ctxirq_tag.sv
module ctxirq_tag
    import ctxirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          queue,
    input  logic          commit,
    input  logic          cur_ctx,
    output logic [DW-1:0] tag_q
);
    always_ff @(posedge clk) begin
        if (rst)         tag_q <= TAG_NONE;
        else if (queue)  tag_q <= {{(DW-1){1'b0}}, cur_ctx};
        else if (commit) tag_q <= TAG_NONE;
    end
endmodule

// File: rtl/ctxirq_bank.sv
module ctxirq_bank
    import ctxirq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_lo,
    input  logic                        wr_hi,
    input  logic [DW-1:0]               wdata,
    input  logic                        tgt,
    output ctx_state_t [NCTX-1:0]       st
);
    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst) begin
                st[g].en   <= '0;
                st[g].mask <= 1'b1;
            end else begin
                if (wr_lo) begin
                    st[g].mask <= wdata[MASK0_BIT + g];
                    if (tgt == 1'(g))
                        st[g].en[EN_LO_W-1:0] <= wdata[EN_LO_W-1:0];
                end
                if (wr_hi && tgt == 1'(g))
                    st[g].en[EN_W-1:EN_LO_W] <= wdata[EN_HI_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ctxirq_flags.sv
module ctxirq_flags
    import ctxirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flag_q
);
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_i) | set_i;
    end
endmodule

// File: rtl/ctxirq_regs.sv
module ctxirq_regs
    import ctxirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              boundary,
    input  logic              defer_queue,
    input  logic              defer_commit,
    input  logic [FLAG_W-1:0] flag_set,
    input  logic [FLAG_W-1:0] flag_clr,
    output logic              active_ctx,
    output logic [DW-1:0]     pending_tag
);
    logic [DW-1:0]         mode_q;
    logic [DW-1:0]         tag_q;
    logic [FLAG_W-1:0]     flag_q;
    ctx_state_t [NCTX-1:0] st;
    logic [NCTX-1:0]       mask_vec;
    logic                  tgt_ctx;
    ctx_state_t            act_st;

    assign active_ctx  = mode_q[CTX_BIT];
    assign pending_tag = tag_q;
    assign tgt_ctx     = (tag_q != TAG_NONE) ? tag_q[0] : active_ctx;
    assign act_st      = st[active_ctx];

    for (genvar g = 0; g < NCTX; g++) begin : g_mask
        assign mask_vec[g] = st[g].mask;
    end

    ctxirq_mode u_mode (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr && reg_addr == A_MODE),
        .wdata(reg_wdata), .boundary(boundary), .mode_q(mode_q)
    );

    ctxirq_tag u_tag (
        .clk(clk), .rst(rst), .queue(defer_queue), .commit(defer_commit),
        .cur_ctx(active_ctx), .tag_q(tag_q)
    );

    ctxirq_bank u_bank (
        .clk(clk), .rst(rst),
        .wr_lo(reg_wr && reg_addr == A_EN_LO),
        .wr_hi(reg_wr && reg_addr == A_EN_HI),
        .wdata(reg_wdata), .tgt(tgt_ctx), .st(st)
    );

    ctxirq_flags u_flags (
        .clk(clk), .rst(rst), .set_i(flag_set), .clr_i(flag_clr), .flag_q(flag_q)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MODE:    reg_rdata = mode_q;
            A_EN_LO:   reg_rdata = {{(DW-NCTX-EN_LO_W){1'b0}}, mask_vec, act_st.en[EN_LO_W-1:0]};
            A_EN_HI:   reg_rdata = act_st.en[EN_W-1:EN_LO_W];
            A_FLAG_LO: reg_rdata = flag_q[DW-1:0];
            A_FLAG_HI: reg_rdata = {{(2*DW-FLAG_W){1'b0}}, flag_q[FLAG_W-1:DW]};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctxirq_regs_chk.sv
module ctxirq_regs_chk
    import ctxirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DW-1:0]     reg_wdata,
    input logic              boundary,
    input logic              defer_queue,
    input logic              defer_commit,
    input logic [FLAG_W-1:0] flag_set,
    input logic [FLAG_W-1:0] flag_clr,
    input logic [DW-1:0]     mode_q,
    input logic [DW-1:0]     tag_q,
    input logic [FLAG_W-1:0] flag_q,
    input logic [NCTX-1:0]   mask_vec
);
    // R2 / R3: without a boundary the context bit never moves, mode writes included
    a_r3_hold_no_boundary: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(mode_q[CTX_BIT]));

    a_r3_lock_ctx1: assert property (@(posedge clk) disable iff (rst)
        (boundary && mode_q[CTX_BIT] && mode_q[1:0] == 2'b01) |=> mode_q[CTX_BIT]);

    a_r3_pingpong: assert property (@(posedge clk) disable iff (rst)
        (boundary && mode_q[1:0] == 2'b00) |=> mode_q[CTX_BIT] != $past(mode_q[CTX_BIT]));

    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_EN_LO) |=> mask_vec == $past(reg_wdata[MASK0_BIT+NCTX-1:MASK0_BIT]));

    a_r8_queue_tag: assert property (@(posedge clk) disable iff (rst)
        defer_queue |=> tag_q == {{(DW-1){1'b0}}, $past(mode_q[CTX_BIT])});

    a_r8_commit_clears: assert property (@(posedge clk) disable iff (rst)
        (defer_commit && !defer_queue) |=> tag_q == TAG_NONE);

    a_r8_tag_range: assert property (@(posedge clk) disable iff (rst)
        (tag_q == TAG_NONE) || (tag_q < DW'(NCTX)));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|flag_set) |=> (flag_q & $past(flag_set)) == $past(flag_set));

    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (|(flag_clr & ~flag_set)) |=> (flag_q & $past(flag_clr & ~flag_set)) == '0);
endmodule

bind ctxirq_regs ctxirq_regs_chk u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .boundary(boundary), .defer_queue(defer_queue), .defer_commit(defer_commit),
    .flag_set(flag_set), .flag_clr(flag_clr), .mode_q(mode_q), .tag_q(tag_q),
    .flag_q(flag_q), .mask_vec(mask_vec)
);

// File: tb/ctxirq_regs_tb.sv
module ctxirq_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        boundary = 1'b0;
    logic        defer_queue = 1'b0;
    logic        defer_commit = 1'b0;
    logic [11:0] flag_set = '0;
    logic [11:0] flag_clr = '0;
    logic        active_ctx;
    logic [7:0]  pending_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;   // 0 read data, 1 pending tag, 2 active context
        logic [7:0] exp;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    event kick;

    always #4 clk = ~clk;

    ctxirq_regs u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .boundary(boundary), .defer_queue(defer_queue),
        .defer_commit(defer_commit), .flag_set(flag_set), .flag_clr(flag_clr),
        .active_ctx(active_ctx), .pending_tag(pending_tag)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(kick);
            while (exp_q.size() > 0) begin
                exp_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                act = (it.sel == 0) ? reg_rdata :
                      (it.sel == 1) ? pending_tag : {7'b0, active_ctx};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic b, input logic q, input logic c,
                        input logic [11:0] s, input logic [11:0] cl);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; boundary = b;
        defer_queue = q; defer_commit = c; flag_set = s; flag_clr = cl;
        @(negedge clk);
        reg_wr = 1'b0; boundary = 1'b0; defer_queue = 1'b0; defer_commit = 1'b0;
        flag_set = '0; flag_clr = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic bnd();
        step(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0);
    endtask

    // Driver: settles the address, pushes the expectation, wakes the monitor.
    task automatic expect_item(input int sel, input logic [2:0] a, input logic [7:0] e, input string req);
        exp_t it;
        reg_addr = a;
        #1;
        it.sel = sel; it.exp = e; it.req = req;
        exp_q.push_back(it);
        -> kick;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        expect_item(0, a, e, req);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, 8'h0C, "R1 mode");
        rd(3'd1, 8'h30, "R1 low enable");
        rd(3'd2, 8'h00, "R1 high enable");
        rd(3'd3, 8'h00, "R1 flags lo");
        rd(3'd4, 8'h00, "R1 flags hi");
        expect_item(1, 3'd0, 8'hFF, "R1 tag");
        expect_item(2, 3'd0, 8'h00, "R1 active");

        // R4 / R5 low byte and masks
        wr(3'd1, 8'h0A);
        rd(3'd1, 8'h0A, "R5 masks cleared, en lo");
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h3F, "R4 bits 7:6 zero");

        // R6 high byte
        wr(3'd2, 8'hA5);
        rd(3'd2, 8'hA5, "R6 high");
        rd(3'd1, 8'h3F, "R6 low untouched");

        // R2 mode write keeps bit 4
        wr(3'd0, 8'h12);
        rd(3'd0, 8'h02, "R2 bit4 kept");
        expect_item(2, 3'd0, 8'h00, "R2 active");

        // R3 swap rule
        bnd();
        expect_item(2, 3'd0, 8'h00, "R3 10 pins ctx0");
        wr(3'd0, 8'h01);
        bnd();
        expect_item(2, 3'd0, 8'h01, "R3 toggle to ctx1");
        rd(3'd0, 8'h11, "R3 mode after toggle");
        bnd();
        expect_item(2, 3'd0, 8'h01, "R3 01 pins ctx1");

        // R7 banking
        rd(3'd2, 8'h00, "R7 ctx1 high empty");
        rd(3'd1, 8'h30, "R7 ctx1 low empty");
        wr(3'd2, 8'h3C);
        wr(3'd1, 8'h35);
        rd(3'd1, 8'h35, "R7 ctx1 low");
        rd(3'd2, 8'h3C, "R7 ctx1 high");
        wr(3'd0, 8'h02);
        bnd();
        expect_item(2, 3'd0, 8'h00, "R3 back to ctx0");
        rd(3'd2, 8'hA5, "R7 ctx0 high untouched");
        rd(3'd1, 8'h3F, "R7 ctx0 low untouched");

        // R8 / R9 deferred write routing
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0, '0);
        expect_item(1, 3'd0, 8'h00, "R8 tag ctx0");
        wr(3'd0, 8'h01);
        bnd();
        expect_item(2, 3'd0, 8'h01, "R9 active ctx1");
        expect_item(1, 3'd0, 8'h00, "R8 tag held across swap");
        wr(3'd2, 8'h77);
        rd(3'd2, 8'h3C, "R9 ctx1 not written");
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, '0, '0);
        expect_item(1, 3'd0, 8'hFF, "R8 commit clears");
        wr(3'd0, 8'h02);
        bnd();
        rd(3'd2, 8'h77, "R9 ctx0 got write");

        // R10 write and swap in the same cycle
        wr(3'd0, 8'h00);
        step(1'b1, 3'd2, 8'h11, 1'b1, 1'b0, 1'b0, '0, '0);
        expect_item(2, 3'd0, 8'h01, "R10 swapped");
        rd(3'd2, 8'h3C, "R10 ctx1 untouched");
        bnd();
        rd(3'd2, 8'h11, "R10 pre-swap target");
        step(1'b1, 3'd0, 8'h03, 1'b1, 1'b0, 1'b0, '0, '0);
        rd(3'd0, 8'h13, "R10 mode write with swap");

        // R8 queue wins over commit
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, '0, '0);
        expect_item(1, 3'd0, 8'h01, "R8 queue wins");
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, '0, '0);
        expect_item(1, 3'd0, 8'hFF, "R8 commit");

        // R11 flags
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 12'hF0F, 12'h000);
        rd(3'd3, 8'h0F, "R11 set lo");
        rd(3'd4, 8'h0F, "R11 set hi, upper zero");
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h0F0, 12'h00F);
        rd(3'd3, 8'hF0, "R11 set and clear");
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h001, 12'h001);
        rd(3'd3, 8'hF1, "R11 set wins");
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 12'hFFF);
        rd(3'd3, 8'h00, "R11 clear lo");
        rd(3'd4, 8'h00, "R11 clear hi");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule